// File: doc/BRIEF.md
# Asynchronous SRAM Write-Timing Monitor

This block watches the pins of an asynchronous static RAM from the side. It samples them on a fast clock and reports any write cycle that breaks the timing rules. It never drives the memory and holds no copy of its contents. Every interval it checks is a count of clock samples, compared against a minimum given as a parameter. One unit is one period of the monitor clock.

A write overlap on a byte lane is a run of samples in which chip enable is low and that lane's write strobe is low. The combined overlap is the union of the lanes. It starts when the later of the two enables falls and ends when the first one rises.

The monitor checks these intervals against their minimums:
- address setup before the overlap starts;
- the pulse width of each lane;
- data setup before the overlap ends;
- data hold after the overlap ends;
- recovery before the next address change.

It also flags a change of address inside an overlap. It flags a test-side data driver that is switched on while the memory may still be driving the bus. The first violation is latched together with a 3-bit code and stays until a synchronous clear. A counter records how many combined overlaps have completed.

Top module: `sram_wr_monitor`

## Requirements
- R1: An address change on a sample where chip enable and at least one lane strobe are both low, including the sample where the overlap starts, raises violation code 1.
- R2: Each lane is timed on its own. If that lane was active for fewer than T_WP samples, then on the first sample where it is inactive again the monitor raises code 2. The output-enable exception in R3 applies.
- R3: If output enable was low on any active sample of a lane's overlap, the minimum for that lane becomes max(T_WP, T_WZ+T_DW). Otherwise it is T_WP.
- R4: Address setup is the number of samples from the last address change to the first sample of the combined overlap. A value below T_AS raises code 3.
- R5: Data setup is the number of samples from the last data change to the first sample after the combined overlap. A value below T_DW raises code 3, provided the data does not change on that sample.
- R6: Data hold is the number of samples from the first sample after the combined overlap to the next data change, counting that sample as zero. A value below T_DH raises code 4.
- R7: Recovery is the number of samples from the first sample after the combined overlap to the next address change. A value below T_WR raises code 5.
- R8: The monitor raises code 6 when, on the same sample, all of the following hold: the driver enable is high, output enable is low, and chip enable is low. The remaining condition is that either no overlap is active, or fewer than T_WZ samples have passed since the overlap started.
- R9: The error flag and code keep the first violation in time. If several violations arise on one sample, the lowest code wins. A synchronous clear zeroes the flag, the code and the counter. The code reads 0 while the flag is low.
- R10: The completed-write counter rises by exactly one on the first sample after each combined overlap.
- R11: After reset the error flag, code and counter are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of flag, code and counter |
| addr | input | ADDR_W | Memory address pins |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | LANES | Per-lane write strobes, active low |
| din | input | LANES*LANE_W | Data pins as seen at the memory |
| drvEn | input | 1 | High while the controller drives the data pins |
| errFlag | output | 1 | Sticky violation flag |
| errCode | output | 3 | Code of the first violation (1 to 6) |
| checkedCnt | output | CNT_W | Number of completed write overlaps |

## Verification
The assertions assume the pins are already synchronous to the sampling clock, so a value is only ever seen on whole samples. They also assume at most one combined write overlap is in flight at a time. The stimulus changes every pin only on the falling clock edge. It builds each write from sample offsets measured against one start point, and it separates writes with idle gaps in which chip enable and all strobes stay high. Each sweep moves one interval away from a clean baseline, so the expected code and the sample where it appears follow from simple arithmetic on those offsets.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [2:0] {
    V_NONE  = 3'd0,
    V_ADDR  = 3'd1,
    V_PULSE = 3'd2,
    V_SETUP = 3'd3,
    V_HOLD  = 3'd4,
    V_RECOV = 3'd5,
    V_BUS   = 3'd6
  } violCode_e;

  localparam int NUM_VIOL = 6;

  typedef struct packed {
    logic ovStart;
    logic ovEnd;
    logic ovActive;
  } ovStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
#(
  parameter int LANES = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             ceN,
  input  logic [LANES-1:0] weN,
  input  logic [NUM_VIOL-1:0] viol,
  output ovStrobe_t        strb,
  output logic [LANES-1:0] laneAct,
  output logic [LANES-1:0] laneEnd,
  output logic             errFlag,
  output logic [2:0]       errCode,
  output logic [CNT_W-1:0] checkedCnt
);

  logic [LANES-1:0] laneActQ;
  logic             anyActQ;
  violCode_e        pick;

  assign laneAct = ~weN & {LANES{~ceN}};
  assign laneEnd = laneActQ & ~laneAct;
  assign anyActQ = |laneActQ;

  always_comb begin
    strb.ovActive = |laneAct;
    strb.ovStart  = strb.ovActive & ~anyActQ;
    strb.ovEnd    = ~strb.ovActive & anyActQ;
  end

  // lowest code wins when several arise on one sample
  always_comb begin
    pick = V_NONE;
    for (int i = NUM_VIOL - 1; i >= 0; i--) begin
      if (viol[i]) pick = violCode_e'(3'(i + 1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneActQ   <= '0;
      errFlag    <= 1'b0;
      errCode    <= 3'd0;
      checkedCnt <= '0;
    end else begin
      laneActQ <= laneAct;
      if (clr) begin
        errFlag    <= 1'b0;
        errCode    <= 3'd0;
        checkedCnt <= '0;
      end else begin
        if (!errFlag && pick != V_NONE) begin
          errFlag <= 1'b1;
          errCode <= pick;
        end
        if (strb.ovEnd) checkedCnt <= checkedCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wt_dp.sv
module wt_dp
  import wt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int T_WP   = 4,
  parameter int T_WZ   = 2,
  parameter int T_DW   = 3,
  parameter int T_DH   = 2,
  parameter int T_AS   = 2,
  parameter int T_WR   = 2,
  parameter int AGE_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              drvEn,
  input  ovStrobe_t         strb,
  input  logic [LANES-1:0]  laneAct,
  input  logic [LANES-1:0]  laneEnd,
  output logic [NUM_VIOL-1:0] viol
);

  localparam int REQ_OE = maxOf(T_WP, T_WZ + T_DW);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] L_WP  = AGE_W'(T_WP);
  localparam logic [AGE_W-1:0] L_OE  = AGE_W'(REQ_OE);
  localparam logic [AGE_W-1:0] L_WZ  = AGE_W'(T_WZ);
  localparam logic [AGE_W-1:0] L_DW  = AGE_W'(T_DW);
  localparam logic [AGE_W-1:0] L_DH  = AGE_W'(T_DH);
  localparam logic [AGE_W-1:0] L_AS  = AGE_W'(T_AS);
  localparam logic [AGE_W-1:0] L_WR  = AGE_W'(T_WR);

  function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] v);
    return (v == AGE_MAX) ? v : v + 1'b1;
  endfunction

  logic              primed;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dinQ;
  logic [AGE_W-1:0]  addrAgeQ, dinAgeQ, ovAgeQ, recAgeQ, holdAgeQ;
  logic [AGE_W-1:0]  addrAgeNow, dinAgeNow, ovAgeNow, recAgeNow, holdAgeNow;
  logic              recPendQ, holdPendQ, recPendNow, holdPendNow;
  logic              addrChg, dinChg;
  logic [LANES-1:0]  laneShort;

  assign addrChg = primed && (addr != addrQ);
  assign dinChg  = primed && (din != dinQ);

  always_comb begin
    addrAgeNow  = addrChg ? '0 : bump(addrAgeQ);
    dinAgeNow   = dinChg ? '0 : bump(dinAgeQ);
    ovAgeNow    = strb.ovStart ? '0 : bump(ovAgeQ);
    recAgeNow   = strb.ovEnd ? '0 : bump(recAgeQ);
    holdAgeNow  = strb.ovEnd ? '0 : bump(holdAgeQ);
    recPendNow  = strb.ovEnd | recPendQ;
    holdPendNow = strb.ovEnd | holdPendQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed    <= 1'b0;
      addrQ     <= '0;
      dinQ      <= '0;
      addrAgeQ  <= AGE_MAX;
      dinAgeQ   <= AGE_MAX;
      ovAgeQ    <= AGE_MAX;
      recAgeQ   <= AGE_MAX;
      holdAgeQ  <= AGE_MAX;
      recPendQ  <= 1'b0;
      holdPendQ <= 1'b0;
    end else begin
      primed    <= 1'b1;
      addrQ     <= addr;
      dinQ      <= din;
      addrAgeQ  <= addrAgeNow;
      dinAgeQ   <= dinAgeNow;
      ovAgeQ    <= ovAgeNow;
      recAgeQ   <= recAgeNow;
      holdAgeQ  <= holdAgeNow;
      recPendQ  <= recPendNow && !addrChg;
      holdPendQ <= holdPendNow && !dinChg && (holdAgeNow < L_DH);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AGE_W-1:0] widthQ;
    logic             oeSeenQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        widthQ  <= '0;
        oeSeenQ <= 1'b0;
      end else begin
        widthQ  <= laneAct[g] ? bump(widthQ) : '0;
        oeSeenQ <= laneAct[g] ? (oeSeenQ | ~oeN) : 1'b0;
      end
    end

    assign laneShort[g] = laneEnd[g] && (widthQ < (oeSeenQ ? L_OE : L_WP));
  end

  always_comb begin
    viol[0] = addrChg && strb.ovActive;
    viol[1] = |laneShort;
    viol[2] = (strb.ovStart && (addrAgeNow < L_AS)) ||
              (strb.ovEnd && !dinChg && (dinAgeNow < L_DW));
    viol[3] = holdPendNow && dinChg && (holdAgeNow < L_DH);
    viol[4] = recPendNow && addrChg && (recAgeNow < L_WR);
    viol[5] = drvEn && !oeN && !ceN && (!strb.ovActive || (ovAgeNow < L_WZ));
  end

endmodule

// File: rtl/sram_wr_monitor.sv
module sram_wr_monitor
  import wt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 8,
  parameter int T_WP   = 4,
  parameter int T_WZ   = 2,
  parameter int T_DW   = 3,
  parameter int T_DH   = 2,
  parameter int T_AS   = 2,
  parameter int T_WR   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ceN,
  input  logic                    oeN,
  input  logic [LANES-1:0]        weN,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    drvEn,
  output logic                    errFlag,
  output logic [2:0]              errCode,
  output logic [CNT_W-1:0]        checkedCnt
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int MAX_T  = maxOf(maxOf(maxOf(T_WP, T_WZ + T_DW), maxOf(T_DH, T_AS)),
                                maxOf(T_WR, T_DW));
  localparam int AGE_W  = $clog2(MAX_T + 2);

  ovStrobe_t           strb;
  logic [LANES-1:0]    laneAct, laneEnd;
  logic [NUM_VIOL-1:0] viol;

  wt_ctrl #(
    .LANES(LANES),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .clr(clr),
    .ceN(ceN),
    .weN(weN),
    .viol(viol),
    .strb(strb),
    .laneAct(laneAct),
    .laneEnd(laneEnd),
    .errFlag(errFlag),
    .errCode(errCode),
    .checkedCnt(checkedCnt)
  );

  wt_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES(LANES),
    .T_WP(T_WP),
    .T_WZ(T_WZ),
    .T_DW(T_DW),
    .T_DH(T_DH),
    .T_AS(T_AS),
    .T_WR(T_WR),
    .AGE_W(AGE_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .addr(addr),
    .din(din),
    .ceN(ceN),
    .oeN(oeN),
    .drvEn(drvEn),
    .strb(strb),
    .laneAct(laneAct),
    .laneEnd(laneEnd),
    .viol(viol)
  );

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clr,
  input logic [ADDR_W-1:0] addr,
  input logic              ceN,
  input logic [LANES-1:0]  weN,
  input logic              errFlag,
  input logic [2:0]        errCode,
  input logic [CNT_W-1:0]  checkedCnt
);

  logic warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= 1'b0;
    else       warm <= 1'b1;
  end

  // R1: address movement inside an overlap must be reported
  p_addr_in_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !clr && !errFlag && !ceN && (weN != '1) && (addr != $past(addr)))
    |=> errFlag);

  // R9: first violation is held
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clr) |=> (errFlag && $stable(errCode)));

  // R9: clear zeroes everything
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (!errFlag && errCode == 3'd0 && checkedCnt == '0));

  // R9: code is nonzero and in range exactly when flagged
  p_code_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag == (errCode != 3'd0)) && (errCode <= 3'd6));

  // R10: counter never jumps by more than one
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> ((checkedCnt == $past(checkedCnt)) ||
              (checkedCnt == $past(checkedCnt) + 1'b1)));

endmodule

bind sram_wr_monitor wt_checker #(
  .ADDR_W(ADDR_W),
  .LANES(LANES),
  .CNT_W(CNT_W)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .clr(clr),
  .addr(addr),
  .ceN(ceN),
  .weN(weN),
  .errFlag(errFlag),
  .errCode(errCode),
  .checkedCnt(checkedCnt)
);

// File: tb/sram_wr_monitor_tb.sv
module sram_wr_monitor_tb;

  localparam int AW = 4, LANES = 2, LW = 8, DW = 16, CW = 8;
  localparam int TWP = 4, TWZ = 2, TDW = 3, TDH = 2, TAS = 2, TWR = 2;
  localparam int REQOE = (TWZ + TDW > TWP) ? TWZ + TDW : TWP;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, clr, ceN, oeN, drvEn;
  logic [AW-1:0] addr;
  logic [1:0]    weN;
  logic [DW-1:0] din;
  logic          errFlag;
  logic [2:0]    errCode;
  logic [CW-1:0] checkedCnt;

  sram_wr_monitor #(
    .ADDR_W(AW), .LANES(LANES), .LANE_W(LW), .CNT_W(CW),
    .T_WP(TWP), .T_WZ(TWZ), .T_DW(TDW), .T_DH(TDH), .T_AS(TAS), .T_WR(TWR)
  ) u_dut (
    .clk(clk), .rstN(rstN), .clr(clr), .addr(addr), .ceN(ceN), .oeN(oeN),
    .weN(weN), .din(din), .drvEn(drvEn),
    .errFlag(errFlag), .errCode(errCode), .checkedCnt(checkedCnt)
  );

  int nRun = 0, nFail = 0;
  int expCnt = 0, expCode = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doClear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    expCnt = 0;
    expCode = 0;
  endtask

  // one write; offsets are samples from the first address change (t=0)
  task automatic trial(input string tag, input int s, input int p0, input int p1,
                       input int oeLow, input int ds, input int h, input int r,
                       input int dz, input int mb, input bit doClr);
    int e, tEnd, bestT, bestC, req;
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    if (doClr) doClear();
    repeat (4) @(negedge clk);
    e = s + ((p0 > p1) ? p0 : p1);
    tEnd = e + ((r > h) ? r : h) + 1;
    a0 = addr;
    d0 = din;
    req = oeLow ? REQOE : TWP;
    bestT = 1 << 20;
    bestC = 0;
    // evaluated in code order; strict < keeps the lower code on ties
    if (s == 0 && bestT > s) begin bestT = s; bestC = 1; end
    if (mb >= s && mb < e && mb < bestT) begin bestT = mb; bestC = 1; end
    if (p0 > 0 && p0 < req && s + p0 < bestT) begin bestT = s + p0; bestC = 2; end
    if (p1 > 0 && p1 < req && s + p1 < bestT) begin bestT = s + p1; bestC = 2; end
    if (s < TAS && s < bestT) begin bestT = s; bestC = 3; end
    if (ds < TDW && e < bestT) begin bestT = e; bestC = 3; end
    if (h < TDH && e + h < bestT) begin bestT = e + h; bestC = 4; end
    if (r < TWR && e + r < bestT) begin bestT = e + r; bestC = 5; end
    if (oeLow != 0 && dz < TWZ && s + dz < e && s + dz < bestT) begin bestT = s + dz; bestC = 6; end
    for (int t = 0; t <= tEnd; t++) begin
      @(negedge clk);
      if (t >= e + r)                addr = a0 + AW'(2);
      else if (mb >= 0 && t >= mb)   addr = a0 + AW'(3);
      else                           addr = a0 + AW'(1);
      weN[0] = !(t >= s && t < s + p0);
      weN[1] = !(t >= s && t < s + p1);
      ceN    = !(t >= s && t < e);
      oeN    = (oeLow == 0);
      drvEn  = (t >= s + dz && t < e);
      if (t < e - ds)     din = d0;
      else if (t < e + h) din = d0 + DW'(1);
      else                din = d0 + DW'(2);
    end
    @(negedge clk);
    oeN = 1'b1;
    @(negedge clk);
    expCnt++;
    if (expCode == 0) expCode = bestC;
    chk({tag, " flag"}, int'(errFlag), int'(expCode != 0));
    chk({tag, " code"}, int'(errCode), expCode);
    chk({"R10 count after ", tag}, int'(checkedCnt), expCnt);
  endtask

  initial begin
    #1500000;
    nRun++;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; clr = 1'b0; ceN = 1'b1; oeN = 1'b1; drvEn = 1'b0;
    weN = 2'b11; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 reset flag", int'(errFlag), 0);
    chk("R11 reset code", int'(errCode), 0);
    chk("R11 reset count", int'(checkedCnt), 0);

    // baseline: s=2 p=6 ds=3 h=2 r=2 dz=3
    trial("R10 clean write", 2, 6, 6, 0, 3, 2, 2, 3, -1, 1);
    for (int oe = 0; oe < 2; oe++) begin
      for (int p = 1; p <= 7; p++) begin
        trial(oe ? "R3 lane0 pulse oe low" : "R2 lane0 pulse", 2, p, 6, oe, 3, 2, 2, 3, -1, 1);
        trial(oe ? "R3 lane1 pulse oe low" : "R2 lane1 pulse", 2, 6, p, oe, 3, 2, 2, 3, -1, 1);
      end
    end
    trial("R2 single lane only", 2, 5, 0, 0, 3, 2, 2, 3, -1, 1);
    for (int s = 0; s <= 3; s++)
      trial(s == 0 ? "R1 R4 setup zero" : "R4 address setup", s, 6, 6, 0, 3, 2, 2, 3, -1, 1);
    for (int ds = 1; ds <= 5; ds++)
      trial("R5 data setup", 2, 6, 6, 0, ds, 2, 2, 3, -1, 1);
    for (int h = 0; h <= 3; h++)
      trial("R6 data hold", 2, 6, 6, 0, 3, h, 2, 3, -1, 1);
    for (int r = 0; r <= 3; r++)
      trial("R7 recovery", 2, 6, 6, 0, 3, 2, r, 3, -1, 1);
    for (int dz = 0; dz <= 3; dz++) begin
      trial("R8 contention oe low", 2, 6, 6, 1, 3, 2, 2, dz, -1, 1);
      trial("R8 driver with oe high", 2, 6, 6, 0, 3, 2, 2, dz, -1, 1);
    end
    trial("R1 address moves mid write", 2, 6, 6, 0, 3, 2, 2, 3, 5, 1);
    trial("R1 address moves at last active", 2, 6, 6, 0, 3, 2, 2, 3, 7, 1);

    // R9: earlier contention beats a later short pulse
    trial("R9 first in time wins", 2, 2, 2, 1, 1, 2, 2, 0, -1, 1);
    // R9: sticky across later writes
    trial("R9 sticky start", 2, 6, 6, 0, 3, 2, 0, 3, -1, 1);
    trial("R9 sticky clean follow", 2, 6, 6, 0, 3, 2, 2, 3, -1, 0);
    trial("R9 sticky other violation", 2, 6, 6, 0, 3, 0, 2, 3, -1, 0);
    doClear();
    @(negedge clk);
    chk("R9 clear flag", int'(errFlag), 0);
    chk("R9 clear code", int'(errCode), 0);
    chk("R9 clear count", int'(checkedCnt), 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule